// File: doc/BRIEF.md
# Partitioned Greater-Than Result Combiner

This block sits behind a SIMD comparator whose data word is cut into `PARTS` equal partitions. Each partition's comparator supplies an equal flag and a greater flag. A run-time gate vector tells the block which partition boundaries are active. An inactive boundary fuses its two neighbours into one wider lane. The block chains the per-partition flags across each lane and reports one result per lane, on the lane's lowest-indexed partition. Lower-indexed partitions are treated as more significant.

A single mode input selects the result. With the mode low, each lane reports strict greater-than. With the mode high, the same chain reports greater-or-equal. When the greater flags are all zero, greater-or-equal reduces to lane equality. Only the seed of each lane's chain changes between the two modes. The block is purely combinational.

Top module: `partcmp_combine`

## Requirements
- R1: With `want_eq`=0 and every bit of `seg_gate` set, `result[i]` equals `gt_flag[i]` for every partition i.
- R2: With `want_eq`=0, for a lane spanning partitions lo..hi, `result[lo]` is 1 exactly when some partition k in lo..hi has `gt_flag[k]`=1 and every partition j with lo <= j < k has `eq_flag[j]`=1. Example for three partitions and no gates: `result[0]` = gt0 | eq0&(gt1 | eq1&gt2).
- R3: With `want_eq`=0, every result bit that is not the lowest partition of its lane is 0.
- R4: With `want_eq`=1 and all greater flags 0, each lane's lowest result bit is the AND of the equal flags across the lane. For three partitions and `seg_gate`=2'b00, `result[0]` = eq0&eq1&eq2.
- R5: With `want_eq`=1, all greater flags 0 and every gate bit set, `result` equals `eq_flag`.
- R6: With `want_eq`=1, a lane's lowest result bit is 1 when the condition of R2 holds for the lane, and also when every partition in the lane has its equal flag set. Otherwise it is 0. The bits of a lane other than its lowest carry no defined value in this mode.
- R7: Gate bit k lies between partition k and partition k+1. When that bit is 1, flags at or above partition k+1 have no effect on any result bit at or below partition k.
- R8: `result` responds to its inputs without any clock or stored state. All-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| eq_flag | input | PARTS | Per-partition equal flag |
| gt_flag | input | PARTS | Per-partition greater flag |
| seg_gate | input | PARTS-1 | Boundary k active (1) splits partitions k and k+1 |
| want_eq | input | 1 | 0: greater-than, 1: greater-or-equal / equality |
| result | output | PARTS | Lane result on each lane's lowest partition |

## Verification
The bound checker tests several properties on every input change. It checks the all-gates-open identities in both modes and the zeroing of non-lowest bits in greater-than mode. It also checks that a result stays clear when no greater flag is set, and that fully equal lanes report 1 in the second mode. The chained value of a wide lane, and the isolation of a lane from its neighbours' flags, are shown only by the bench. The bench sweeps every combination of mode, gates and flags for three partitions against a scanning reference model, and adds a targeted isolation scenario.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   // upper bound on partitions supported by the library block
   localparam int unsigned GTC_MAX_PARTS = 8;
   localparam int unsigned GTC_MIN_PARTS = 2;

   // lane boundary decode result for one partition
   typedef struct packed {
      logic head;   // lowest partition of its lane
      logic tail;   // highest partition of its lane
   } gtc_lane_pos_t;
endpackage

// File: rtl/gtc_lane_map.sv
module gtc_lane_map
   import gtc_pkg::*;
#(
   parameter int unsigned PARTS = 3
) (
   input  logic [PARTS-2:0]      gate,
   output gtc_lane_pos_t [PARTS-1:0] pos
);
   localparam int unsigned LAST = PARTS - 1;

   genvar j;
   generate
      for (j = 0; j < PARTS; j++) begin : g_pos
         if (j == 0) begin : g_first
            assign pos[j].head = 1'b1;
         end else begin : g_inner_head
            assign pos[j].head = gate[j-1];
         end
         if (j == LAST) begin : g_last
            assign pos[j].tail = 1'b1;
         end else begin : g_inner_tail
            assign pos[j].tail = gate[j];
         end
      end
   endgenerate
endmodule

// File: rtl/gtc_link.sv
module gtc_link (
   input  logic eq_in,
   input  logic gt_in,
   input  logic below,   // verdict of the less significant partitions
   output logic verdict
);
   // this partition decides unless equal, in which case defer downward
   assign verdict = gt_in | (eq_in & below);
endmodule

// File: rtl/partcmp_combine.sv
module partcmp_combine
   import gtc_pkg::*;
#(
   parameter int unsigned PARTS = 3
) (
   input  logic [PARTS-1:0] eq_flag,
   input  logic [PARTS-1:0] gt_flag,
   input  logic [PARTS-2:0] seg_gate,
   input  logic             want_eq,
   output logic [PARTS-1:0] result
);
   localparam int unsigned LAST = PARTS - 1;

   generate
      if (PARTS < GTC_MIN_PARTS || PARTS > GTC_MAX_PARTS) begin : g_bad_parts
         $error("partcmp_combine: PARTS out of supported range");
      end
   endgenerate

   gtc_lane_pos_t [PARTS-1:0] pos;
   logic [PARTS-1:0] below;
   logic [PARTS-1:0] chain;

   gtc_lane_map #(.PARTS(PARTS)) u_map (
      .gate (seg_gate),
      .pos  (pos)
   );

   genvar j;
   generate
      for (j = 0; j < PARTS; j++) begin : g_part
         // seed at lane end: mode bit stands in for "tie counts as win"
         if (j == LAST) begin : g_top_seed
            assign below[j] = want_eq;
         end else begin : g_link_seed
            assign below[j] = pos[j].tail ? want_eq : chain[j+1];
         end

         gtc_link u_link (
            .eq_in   (eq_flag[j]),
            .gt_in   (gt_flag[j]),
            .below   (below[j]),
            .verdict (chain[j])
         );

         // greater-than mode clears non-head bits
         assign result[j] = (pos[j].head | want_eq) & chain[j];
      end
   endgenerate
endmodule

// File: rtl/partcmp_combine_chk.sv
module partcmp_combine_chk #(
   parameter int unsigned PARTS = 3
) (
   input logic [PARTS-1:0] eq_flag,
   input logic [PARTS-1:0] gt_flag,
   input logic [PARTS-2:0] seg_gate,
   input logic             want_eq,
   input logic [PARTS-1:0] result
);
   logic [PARTS-1:0] is_head;
   logic [PARTS-1:0] all_ones;

   always_comb begin
      is_head = '0;
      is_head[0] = 1'b1;
      for (int k = 1; k < PARTS; k++) is_head[k] = seg_gate[k-1];
      all_ones = '1;
   end

   always_comb begin
      // R1
      if (!want_eq && (&seg_gate))
         all_gates_gt_chk: assert (result == gt_flag);
      // R3
      if (!want_eq)
         nonhead_zero_chk: assert ((result & ~is_head) == '0);
      // R2
      if (!want_eq && gt_flag == '0)
         no_gt_no_win_chk: assert (result == '0);
      // R5
      if (want_eq && (&seg_gate) && gt_flag == '0)
         all_gates_eq_chk: assert (result == eq_flag);
      // R4
      if (want_eq && seg_gate == '0 && gt_flag == '0)
         whole_word_eq_chk: assert (result[0] == (&eq_flag));
      // R6
      if (want_eq && eq_flag == all_ones)
         tie_wins_chk: assert ((result & is_head) == is_head);
   end
endmodule

bind partcmp_combine partcmp_combine_chk #(.PARTS(PARTS)) u_chk (
   .eq_flag  (eq_flag),
   .gt_flag  (gt_flag),
   .seg_gate (seg_gate),
   .want_eq  (want_eq),
   .result   (result)
);

// File: tb/partcmp_combine_test.sv
`timescale 1ns/1ps
module partcmp_combine_test;
   localparam int NP = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [NP-1:0] eq_flag, gt_flag, result;
   logic [NP-2:0] seg_gate;
   logic          want_eq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   partcmp_combine #(.PARTS(NP)) uut (
      .eq_flag(eq_flag), .gt_flag(gt_flag), .seg_gate(seg_gate),
      .want_eq(want_eq), .result(result)
   );

   // expected verdict of a lane lo..hi by scanning from most significant
   function automatic bit lane_ref(int lo, int hi, logic [NP-1:0] eq,
                                   logic [NP-1:0] gt, logic m);
      for (int k = lo; k <= hi; k++) begin
         if (gt[k]) return 1'b1;
         if (!eq[k]) return 1'b0;
      end
      return m;
   endfunction

   task automatic chk(string req, logic a, logic e, int bitpos);
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s bit%0d mode=%0b gate=%b eq=%b gt=%b actual=%b expected=%b",
                  req, bitpos, want_eq, seg_gate, eq_flag, gt_flag, a, e);
      end
   endtask

   task automatic compare_all();
      int lo = 0;
      for (int p = 0; p < NP; p++) begin
         if (p == NP-1 || seg_gate[p]) begin
            // lane lo..p
            for (int q = lo; q <= p; q++) begin
               if (q == lo) begin
                  if (!want_eq)
                     chk(((&seg_gate) ? "R1" : "R2"), result[q],
                         lane_ref(lo, p, eq_flag, gt_flag, 1'b0), q);
                  else if (gt_flag == '0)
                     chk(((&seg_gate) ? "R5" : "R4"), result[q],
                         lane_ref(lo, p, eq_flag, gt_flag, 1'b1), q);
                  else
                     chk("R6", result[q],
                         lane_ref(lo, p, eq_flag, gt_flag, 1'b1), q);
               end else if (!want_eq) begin
                  chk("R3", result[q], 1'b0, q);
               end
            end
            lo = p + 1;
         end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic save;
      eq_flag = '0; gt_flag = '0; seg_gate = '0; want_eq = 1'b0;
      @(negedge clk);
      // R8: zero inputs, no clock needed
      total++;
      if (result !== '0) begin
         bad++;
         $display("FAIL R8 actual=%b expected=000", result);
      end

      // full sweep, one combination per clock
      for (int m = 0; m < 2; m++)
         for (int g = 0; g < (1 << (NP-1)); g++)
            for (int e = 0; e < (1 << NP); e++)
               for (int t = 0; t < (1 << NP); t++) begin
                  @(posedge clk);
                  want_eq  = m[0];
                  seg_gate = g[NP-2:0];
                  eq_flag  = e[NP-1:0];
                  gt_flag  = t[NP-1:0];
                  @(negedge clk);
                  compare_all();
               end

      // R7: boundary 1 active, upper partition flags must not leak down
      for (int m = 0; m < 2; m++) begin
         @(posedge clk);
         want_eq = m[0]; seg_gate = 2'b10;
         eq_flag = 3'b011; gt_flag = 3'b000;
         @(negedge clk);
         save = result[0];
         chk("R7", save, m[0], 0);
         @(posedge clk);
         eq_flag = 3'b111; gt_flag = 3'b100;
         @(negedge clk);
         chk("R7", result[0], save, 0);
      end

      // R8: output follows input mid-cycle without a clock edge
      @(posedge clk);
      want_eq = 1'b0; seg_gate = 2'b11; gt_flag = 3'b000; eq_flag = 3'b000;
      #1;
      gt_flag = 3'b101;
      #0.5;
      total++;
      if (result !== 3'b101) begin
         bad++;
         $display("FAIL R8 actual=%b expected=101", result);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule